// File: doc/BRIEF.md
# I2C Master Bit-Timing Generator

This block turns a fast bus clock into the SCL and SDA waveforms that a single I2C master needs when it writes. The user side issues one-cycle commands: open a transfer (START), send one data bit, or close the transfer (STOP). While a command runs the block is busy. When the last line change of that command appears on the bus, the block pulses `done` and becomes ready again. Both lines are driven open-drain style. An enable of 1 pulls the line low, and an enable of 0 releases it to a high level.

All bus timing comes from five inputs: a 2-bit scale code, an SCL divider and three hold counts. The scale code selects a factor F of 1, 2 or 4. That factor multiplies the divider and every hold count, so one code slows the whole bus uniformly. All five inputs are sampled at the moment a command is accepted. Address and byte framing, acknowledge sampling, arbitration and clock stretching belong to the logic around this block.

Top module: `i2c_bit_timer`

## Requirements
- R1: After reset, `scl_oe` and `sda_oe` are 0 (both lines high), `ready` is 1, `done` is 0 and `config_error` is 0.
- R2: `mult_code` 0, 1 and 2 select factor F = 1, 2 and 4. The scaled period is P = F × max(`scl_div`, 2). A bit command holds SCL low for L = P − floor(P/2) cycles and then high for H = floor(P/2) cycles, counted from the clock edge that accepts it. When P is odd, the extra cycle goes to the low part.
- R3: In a bit command, SDA keeps its previous level for Hd = min(F × `sda_hold_val`, L − 1) cycles after acceptance and then takes `bit_val`. SDA therefore never changes while SCL is high during a data bit.
- R4: A START accepted while SCL is high keeps both lines high for H cycles. It then drives SDA low with SCL still high for Ts = max(F × `start_hold_val`, 1) cycles, and then drives SCL low. The bus is left with both lines low.
- R5: A START accepted while SCL is low first runs a low phase. SDA keeps its level for Hd cycles and is then released, for a total of L low cycles. The START then continues exactly as in R4.
- R6: A STOP holds SCL low for L cycles, with SDA driven low after Hd cycles. It then releases SCL with SDA low for Tp = max(F × `stop_hold_val`, 1) cycles, and then releases SDA. The same sequence runs even when no transfer was open.
- R7: `ready` is low from the cycle after acceptance until the command completes. In the completion cycle `done` is 1 for exactly one cycle, the final line levels are already visible, and `ready` is 1 again. The final levels are: after a START, both lines low; after a bit, SCL low and SDA equal to the bit; after a STOP, both lines high.
- R8: `mult_code` = 3 behaves as factor 1 and sets `config_error` one cycle later. The flag stays set until the next reset, even after the code changes.
- R9: A command issued while `ready` is low is ignored. Changes to the timing inputs or to `bit_val` during a running command have no effect on it.
- R10: When several command inputs are high in the same accepting cycle, START wins over STOP, and STOP wins over a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mult_code | input | 2 | Timing scale code (0:×1, 1:×2, 2:×4, 3:invalid) |
| scl_div | input | DIV_W | SCL period divider before scaling |
| sda_hold_val | input | HOLD_W | SDA hold after SCL falls, before scaling |
| start_hold_val | input | HOLD_W | SCL hold after a START edge, before scaling |
| stop_hold_val | input | HOLD_W | SDA delay after SCL rises at a STOP, before scaling |
| cmd_start | input | 1 | One-cycle START request |
| cmd_bit | input | 1 | One-cycle data-bit request |
| cmd_stop | input | 1 | One-cycle STOP request |
| bit_val | input | 1 | Data level for a bit command |
| ready | output | 1 | Idle and able to accept a command |
| done | output | 1 | One-cycle pulse when a command completes |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| config_error | output | 1 | Sticky flag for an invalid scale code |

## Verification
The hardest cases to reach are those where the outcome depends on the bus state a command inherits. These include a repeated START from a low SCL, a STOP with no open transfer, and a bit following a STOP. Another hard case is a scaled SDA hold that exceeds the low half-period and must be clamped. The stimulus chains random command sequences, so that every command meets whatever line levels the previous one left. Directed cases force clamping, odd and tiny periods, simultaneous command requests and the invalid scale code. During random commands, a busy-time command pulse is injected together with new random timing inputs. A cycle-by-cycle model of the expected waveform then shows that neither one altered the running command.

// File: rtl/i2c_tmr_pkg.sv
package i2c_tmr_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_BIT   = 2'd1,
        OP_STOP  = 2'd2
    } op_e;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_LOA   = 3'd1,   // SCL low, SDA still at old level (hold)
        PH_LOB   = 3'd2,   // SCL low, SDA at new level
        PH_HI    = 3'd3,   // SCL high, SDA steady
        PH_SHOLD = 3'd4    // SCL high, SDA low after a START edge
    } ph_e;

endpackage

// File: rtl/i2c_tmr_scale.sv
module i2c_tmr_scale #(
    parameter int DIV_W  = 8,
    parameter int HOLD_W = 8,
    parameter int CNT_W  = 10
) (
    input  logic [1:0]        mult_code,
    input  logic [DIV_W-1:0]  scl_div,
    input  logic [HOLD_W-1:0] sda_hold_val,
    input  logic [HOLD_W-1:0] start_hold_val,
    input  logic [HOLD_W-1:0] stop_hold_val,
    output logic [CNT_W-1:0]  len_lo,
    output logic [CNT_W-1:0]  len_hi,
    output logic [CNT_W-1:0]  len_hd,
    output logic [CNT_W-1:0]  len_st,
    output logic [CNT_W-1:0]  len_sp,
    output logic              code_bad
);

    logic [1:0]       shift;
    logic [DIV_W-1:0] div_eff;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] hd_raw;
    logic [CNT_W-1:0] hd_lim;
    logic [CNT_W-1:0] st_raw;
    logic [CNT_W-1:0] sp_raw;

    always_comb begin
        case (mult_code)
            2'b01:   shift = 2'd1;
            2'b10:   shift = 2'd2;
            default: shift = 2'd0;   // code 3 falls back to factor 1
        endcase
        code_bad = (mult_code == 2'b11);

        div_eff = (scl_div < DIV_W'(2)) ? DIV_W'(2) : scl_div;
        period  = CNT_W'(div_eff) << shift;
        len_hi  = period >> 1;
        len_lo  = period - len_hi;

        hd_raw  = CNT_W'(sda_hold_val) << shift;
        hd_lim  = len_lo - CNT_W'(1);
        len_hd  = (hd_raw > hd_lim) ? hd_lim : hd_raw;

        st_raw  = CNT_W'(start_hold_val) << shift;
        sp_raw  = CNT_W'(stop_hold_val) << shift;
        len_st  = (st_raw == '0) ? CNT_W'(1) : st_raw;
        len_sp  = (sp_raw == '0) ? CNT_W'(1) : sp_raw;
    end

endmodule

// File: rtl/i2c_tmr_count.sv
module i2c_tmr_count #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - W'(1);
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer
    import i2c_tmr_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mult_code,
    input  logic [DIV_W-1:0]  scl_div,
    input  logic [HOLD_W-1:0] sda_hold_val,
    input  logic [HOLD_W-1:0] start_hold_val,
    input  logic [HOLD_W-1:0] stop_hold_val,
    input  logic              cmd_start,
    input  logic              cmd_bit,
    input  logic              cmd_stop,
    input  logic              bit_val,
    output logic              ready,
    output logic              done,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              config_error
);

    localparam int WIDEST = (DIV_W > HOLD_W) ? DIV_W : HOLD_W;
    localparam int CNT_W  = WIDEST + 2;

    typedef struct packed {
        ph_e              phase;
        op_e              op;
        logic             bitv;
        logic             scl;
        logic             sda;
        logic             done;
        logic             cfg_err;
        logic [CNT_W-1:0] lo;
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] hd;
        logic [CNT_W-1:0] st;
        logic [CNT_W-1:0] sp;
    } st_t;

    st_t st_d, st_q;

    logic [CNT_W-1:0] now_lo, now_hi, now_hd, now_st, now_sp;
    logic             now_bad;
    logic             cnt_zero;
    logic             go;
    logic [CNT_W-1:0] ld_val;
    ph_e              nxt;
    logic             accept;
    logic             lvl_b;

    i2c_tmr_scale #(
        .DIV_W (DIV_W),
        .HOLD_W(HOLD_W),
        .CNT_W (CNT_W)
    ) u_scale (
        .mult_code     (mult_code),
        .scl_div       (scl_div),
        .sda_hold_val  (sda_hold_val),
        .start_hold_val(start_hold_val),
        .stop_hold_val (stop_hold_val),
        .len_lo        (now_lo),
        .len_hi        (now_hi),
        .len_hd        (now_hd),
        .len_st        (now_st),
        .len_sp        (now_sp),
        .code_bad      (now_bad)
    );

    i2c_tmr_count #(
        .W(CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (go),
        .load_val(ld_val),
        .zero    (cnt_zero)
    );

    always_comb begin
        st_d         = st_q;
        st_d.done    = 1'b0;
        st_d.cfg_err = st_q.cfg_err | now_bad;
        go           = 1'b0;
        nxt          = PH_IDLE;
        ld_val       = '0;
        accept       = (st_q.phase == PH_IDLE) && (cmd_start || cmd_bit || cmd_stop);

        // decide whether a phase is entered this cycle, and which
        if (accept) begin
            st_d.op   = cmd_start ? OP_START : (cmd_stop ? OP_STOP : OP_BIT);
            st_d.bitv = bit_val;
            st_d.lo   = now_lo;
            st_d.hi   = now_hi;
            st_d.hd   = now_hd;
            st_d.st   = now_st;
            st_d.sp   = now_sp;
            go        = 1'b1;
            if (st_d.op == OP_START && st_q.scl) begin
                nxt = PH_HI;
            end else if (now_hd != '0) begin
                nxt = PH_LOA;
            end else begin
                nxt = PH_LOB;
            end
        end else if (st_q.phase != PH_IDLE && cnt_zero) begin
            go = 1'b1;
            case (st_q.phase)
                PH_LOA:  nxt = PH_LOB;
                PH_LOB:  nxt = PH_HI;
                PH_HI:   nxt = (st_q.op == OP_START) ? PH_SHOLD : PH_IDLE;
                default: nxt = PH_IDLE;
            endcase
        end

        // level SDA takes once the hold part of a low phase has passed
        case (st_d.op)
            OP_START: lvl_b = 1'b1;
            OP_STOP:  lvl_b = 1'b0;
            default:  lvl_b = st_d.bitv;
        endcase

        // enter the chosen phase: line levels and counter length
        if (go) begin
            st_d.phase = nxt;
            case (nxt)
                PH_LOA: begin
                    st_d.scl = 1'b0;
                    ld_val   = st_d.hd - CNT_W'(1);
                end
                PH_LOB: begin
                    st_d.scl = 1'b0;
                    st_d.sda = lvl_b;
                    ld_val   = st_d.lo - st_d.hd - CNT_W'(1);
                end
                PH_HI: begin
                    st_d.scl = 1'b1;
                    st_d.sda = lvl_b;
                    ld_val   = ((st_d.op == OP_STOP) ? st_d.sp : st_d.hi) - CNT_W'(1);
                end
                PH_SHOLD: begin
                    st_d.scl = 1'b1;
                    st_d.sda = 1'b0;
                    ld_val   = st_d.st - CNT_W'(1);
                end
                default: begin
                    st_d.done = 1'b1;
                    case (st_d.op)
                        OP_START: begin st_d.scl = 1'b0; st_d.sda = 1'b0;      end
                        OP_STOP:  begin st_d.scl = 1'b1; st_d.sda = 1'b1;      end
                        default:  begin st_d.scl = 1'b0; st_d.sda = st_d.bitv; end
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.phase   <= PH_IDLE;
            st_q.op      <= OP_BIT;
            st_q.scl     <= 1'b1;
            st_q.sda     <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready        = (st_q.phase == PH_IDLE);
    assign done         = st_q.done;
    assign scl_oe       = ~st_q.scl;
    assign sda_oe       = ~st_q.sda;
    assign config_error = st_q.cfg_err;

    // R7: completion pulse lasts exactly one cycle
    a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: an accepted command makes the block busy
    a_r7_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && (cmd_start || cmd_bit || cmd_stop)) |=> !ready);

    // R8: invalid-code flag is sticky
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        config_error |=> config_error);

    // R6: a completed STOP leaves both lines released
    a_r6_stop_released: assert property (@(posedge clk) disable iff (!rst_n)
        (done && st_q.op == OP_STOP) |-> (!scl_oe && !sda_oe));

    // R3: during a data bit SDA only moves while SCL is low
    a_r3_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && st_q.op == OP_BIT && !$stable(sda_oe)) |-> scl_oe);

    // R4: within a START, SDA is pulled low only while SCL is high
    a_r4_start_edge_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && st_q.op == OP_START && $rose(sda_oe)) |-> !scl_oe);

endmodule

// File: tb/sim_i2c_bit_timer.sv
module sim_i2c_bit_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mult_code = '0;
    logic [7:0] scl_div = '0;
    logic [7:0] sda_hold_val = '0;
    logic [7:0] start_hold_val = '0;
    logic [7:0] stop_hold_val = '0;
    logic       cmd_start = 1'b0;
    logic       cmd_bit = 1'b0;
    logic       cmd_stop = 1'b0;
    logic       bit_val = 1'b0;
    logic       ready, done, scl_oe, sda_oe, config_error;

    int  n_checks = 0;
    int  n_fails = 0;
    bit  m_scl = 1'b1;
    bit  m_sda = 1'b1;

    always #10 clk = ~clk;

    i2c_bit_timer #(.DIV_W(8), .HOLD_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .mult_code(mult_code), .scl_div(scl_div),
        .sda_hold_val(sda_hold_val), .start_hold_val(start_hold_val),
        .stop_hold_val(stop_hold_val), .cmd_start(cmd_start), .cmd_bit(cmd_bit),
        .cmd_stop(cmd_stop), .bit_val(bit_val), .ready(ready), .done(done),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .config_error(config_error)
    );

    task automatic chk(input bit ok, input string tag, input string msg);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    function automatic int factor(input logic [1:0] c);
        return (c == 2'd1) ? 2 : ((c == 2'd2) ? 4 : 1);
    endfunction

    task automatic rand_cfg();
        mult_code      = 2'($urandom_range(0, 2));
        scl_div        = 8'($urandom_range(0, 24));
        sda_hold_val   = 8'($urandom_range(0, 14));
        start_hold_val = 8'($urandom_range(0, 10));
        stop_hold_val  = 8'($urandom_range(0, 10));
    endtask

    // Issue one command and compare the full waveform against the model.
    task automatic issue(input bit s, input bit b, input bit p, input bit bv,
                         input bit ign, input string tag);
        int F, P, de, L, H, hd, ts, tp, op, n, N, acc, k_bad;
        int len[6];
        bit ls[6];
        bit ld[6];
        bit es, ed, lb, xs, xd, bad_lvl, bad_hs;
        string msg;
        F  = factor(mult_code);
        de = (scl_div < 2) ? 2 : int'(scl_div);
        P  = F * de;
        H  = P / 2;
        L  = P - H;
        hd = F * int'(sda_hold_val);
        if (hd > L - 1) hd = L - 1;
        ts = F * int'(start_hold_val);
        if (ts == 0) ts = 1;
        tp = F * int'(stop_hold_val);
        if (tp == 0) tp = 1;
        op = s ? 0 : (p ? 2 : 1);
        n  = 0;
        if (op == 0 && m_scl) begin
            len[n] = H; ls[n] = 1'b1; ld[n] = 1'b1; n++;
        end else begin
            lb = (op == 0) ? 1'b1 : ((op == 2) ? 1'b0 : bv);
            if (hd > 0) begin
                len[n] = hd; ls[n] = 1'b0; ld[n] = m_sda; n++;
            end
            len[n] = L - hd; ls[n] = 1'b0; ld[n] = lb; n++;
            len[n] = (op == 2) ? tp : H; ls[n] = 1'b1; ld[n] = lb; n++;
        end
        if (op == 0) begin
            len[n] = ts; ls[n] = 1'b1; ld[n] = 1'b0; n++;
        end
        es = (op == 2);
        ed = (op == 2) ? 1'b1 : ((op == 1) ? bv : 1'b0);
        N  = 0;
        for (int j = 0; j < n; j++) N += len[j];

        @(negedge clk);
        cmd_start = s; cmd_bit = b; cmd_stop = p; bit_val = bv;
        bad_lvl = 1'b0; bad_hs = 1'b0; k_bad = 0; msg = "";
        for (int k = 1; k <= N + 2; k++) begin
            @(negedge clk);
            if (k == 1) begin
                if (ign) begin
                    cmd_start = 1'($urandom_range(0, 1));
                    cmd_stop  = 1'($urandom_range(0, 1));
                    cmd_bit   = 1'b1;
                    bit_val   = ~bv;
                    rand_cfg();
                end else begin
                    cmd_start = 1'b0; cmd_bit = 1'b0; cmd_stop = 1'b0;
                end
            end else if (k == 2) begin
                cmd_start = 1'b0; cmd_bit = 1'b0; cmd_stop = 1'b0;
            end
            if (k <= N) begin
                acc = 0;
                xs = es; xd = ed;
                for (int j = 0; j < n; j++) begin
                    if (k > acc && k <= acc + len[j]) begin
                        xs = ls[j]; xd = ld[j];
                    end
                    acc += len[j];
                end
            end else begin
                xs = es; xd = ed;
            end
            if (((~scl_oe) !== xs || (~sda_oe) !== xd) && !bad_lvl) begin
                bad_lvl = 1'b1;
                msg = $sformatf("cycle %0d scl=%b sda=%b expected scl=%b sda=%b",
                                k, ~scl_oe, ~sda_oe, xs, xd);
            end
            if (!bad_hs) begin
                if ((k <= N && (ready !== 1'b0 || done !== 1'b0)) ||
                    (k == N + 1 && (ready !== 1'b1 || done !== 1'b1)) ||
                    (k == N + 2 && (ready !== 1'b1 || done !== 1'b0))) begin
                    bad_hs = 1'b1;
                    k_bad  = k;
                end
            end
        end
        chk(!bad_lvl, tag, msg);
        chk(!bad_hs, "R7", $sformatf("cycle %0d of %0d: ready=%b done=%b (expected busy until completion pulse)",
                                     k_bad, N, ready, done));
        m_scl = es;
        m_sda = ed;
    endtask

    task automatic set_cfg(input logic [1:0] c, input logic [7:0] dv, input logic [7:0] h,
                           input logic [7:0] st, input logic [7:0] sp);
        mult_code = c; scl_div = dv; sda_hold_val = h; start_hold_val = st; stop_hold_val = sp;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_scl = 1'b1;
        m_sda = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        n_fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        set_cfg(2'd0, 8'd10, 8'd2, 8'd3, 8'd4);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(scl_oe == 1'b0 && sda_oe == 1'b0 && ready == 1'b1 && done == 1'b0 && config_error == 1'b0,
            "R1", $sformatf("scl_oe=%b sda_oe=%b ready=%b done=%b err=%b expected 0 0 1 0 0",
                            scl_oe, sda_oe, ready, done, config_error));

        // directed sequence
        issue(1, 0, 0, 0, 0, "R4 start from idle");
        issue(0, 1, 0, 1, 0, "R2,R3 bit one");
        issue(0, 1, 0, 0, 0, "R2,R3 bit zero");
        issue(0, 1, 0, 1, 1, "R9 busy command and input change ignored");
        issue(1, 0, 0, 0, 0, "R5 repeated start");
        set_cfg(2'd1, 8'd6, 8'd9, 8'd2, 8'd3);
        issue(0, 1, 0, 1, 0, "R3 hold clamped to low phase");
        set_cfg(2'd0, 8'd7, 8'd1, 8'd2, 8'd2);
        issue(0, 1, 0, 0, 0, "R2 odd period");
        set_cfg(2'd0, 8'd1, 8'd0, 8'd0, 8'd0);
        issue(0, 1, 0, 1, 0, "R2 tiny divider");
        set_cfg(2'd2, 8'd5, 8'd1, 8'd0, 8'd2);
        issue(0, 0, 1, 0, 0, "R6 stop");
        issue(0, 0, 1, 0, 0, "R6 stop with no open transfer");
        issue(0, 1, 0, 1, 0, "R2 bit after stop");
        issue(1, 1, 1, 0, 0, "R10 start wins");
        issue(0, 1, 1, 1, 0, "R10 stop wins over bit");
        issue(1, 0, 0, 0, 0, "R4 start with zero hold");

        // R8 invalid code
        set_cfg(2'd3, 8'd6, 8'd2, 8'd1, 8'd1);
        repeat (2) @(negedge clk);
        chk(config_error == 1'b1, "R8", $sformatf("config_error=%b expected 1", config_error));
        issue(0, 1, 0, 1, 0, "R8 code 3 runs as factor 1");
        set_cfg(2'd0, 8'd6, 8'd2, 8'd1, 8'd1);
        issue(0, 0, 1, 0, 0, "R8 after code fix");
        chk(config_error == 1'b1, "R8", $sformatf("sticky config_error=%b expected 1", config_error));

        // random commands
        for (int i = 0; i < 80; i++) begin
            int sel;
            bit ign;
            rand_cfg();
            sel = int'($urandom_range(0, 5));
            ign = ($urandom_range(0, 3) == 0);
            case (sel)
                0:       issue(1, 0, 0, 0, ign, "R4,R5 random start");
                1:       issue(0, 0, 1, 0, ign, "R6 random stop");
                default: issue(0, 1, 0, 1'($urandom_range(0, 1)), ign, "R2,R3,R9 random bit");
            endcase
        end

        do_reset();
        chk(config_error == 1'b0 && scl_oe == 1'b0 && sda_oe == 1'b0 && ready == 1'b1,
            "R8", $sformatf("after reset err=%b scl_oe=%b sda_oe=%b ready=%b expected 0 0 0 1",
                            config_error, scl_oe, sda_oe, ready));

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

endmodule